// File: doc/BRIEF.md
# Run-Time Memory Overlay Chip-Select Decoder

This block turns a 16-bit processor address into chip selects for console ROM, peripheral ROM, cartridge space, a slow external RAM expansion, fast internal RAM and the video chip. An eight-bit control latch sits in the serial bit-I/O space. Software writes one bit at a time into that latch to change the memory map while the system runs.

With the latch clear, the address space keeps its normal layout. Internal RAM serves the two expansion areas, and the ROM, peripheral ROM and cartridge areas go to their own devices. Setting one latch bit moves a ROM-type area onto internal RAM. Setting one of two other bits hands an expansion area to the external RAM. A further bit stretches every access to the video chip by one clock.

Chip selects follow the address and the latch combinationally. A latch write takes effect from the clock edge that captures it. A typical use is to shadow the system ROM: enable RAM over the peripheral area, copy the ROM into it, enable RAM over the ROM area, copy the data back, then release the peripheral area.

Top module: `ovl_overlay_decoder`

## Requirements
- R1: After reset every latch bit is 0. Reading any latch bit back returns 0, and the map is the normal one (as given in R3 to R8 with every bit clear).
- R2: While `mem_en` is high, at most one chip select is high. While `mem_en` is low, all chip selects are low.
- R3: Latch bit 0 chooses the owner of 0x0000–0x1FFF: `cs_rom` when the bit is 0, `cs_ram` when it is 1.
- R4: Latch bit 1 chooses the owner of 0x4000–0x5FFF: `cs_prom` when the bit is 0, `cs_ram` when it is 1.
- R5: Latch bit 2 chooses the owner of 0x6000–0x7FFF: `cs_cart` when the bit is 0, `cs_ram` when it is 1.
- R6: Latch bit 3 chooses the owner of 0x2000–0x3FFF: `cs_ram` when the bit is 0, `cs_ext` when it is 1.
- R7: Latch bit 4 chooses the owner of 0xA000–0xFFFF: `cs_ram` when the bit is 0, `cs_ext` when it is 1.
- R8: 0x8800–0x8FFF always selects `cs_vid`. The rest of 0x8000–0x9FFF selects nothing. No latch bit changes this region.
- R9: While a ROM-type area (R3, R4, R5) is not overlaid, `cs_ram` stays low for every access to it, so no write reaches the shadow RAM.
- R10: When latch bit 5 is 1, a video access that begins in a cycle drives `wait_req` high in the next cycle, for exactly one clock. A video access begins when `cs_vid` is high and was not high in the previous cycle. When bit 5 is 0, `wait_req` stays low.
- R11: A high `bio_wstb` at bit address 0x400+k (k = 0..7) writes `bio_wdata` into latch bit k at that clock edge. A strobe at any other bit address changes no latch bit.
- R12: `bio_rdata` combinationally returns latch bit k when `bio_addr` is 0x400+k. For any other bit address it returns 0. Bits 6 and 7 hold and return whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_en | input | 1 | Memory access in progress |
| addr | input | 16 | Processor address |
| bio_addr | input | 12 | Bit-I/O bit address |
| bio_wdata | input | 1 | Bit-I/O write data |
| bio_wstb | input | 1 | Bit-I/O write strobe |
| bio_rdata | output | 1 | Bit-I/O read data (latch readback) |
| cs_rom | output | 1 | Console ROM select |
| cs_prom | output | 1 | Peripheral ROM select |
| cs_cart | output | 1 | Cartridge select |
| cs_ext | output | 1 | External RAM expansion select |
| cs_ram | output | 1 | Internal RAM select |
| cs_vid | output | 1 | Video chip select |
| wait_req | output | 1 | One-clock wait-state request |

## Verification
The assertions take two things for granted. First, `addr` holds steady through each clock in which `mem_en` is high, so a change in the select can come only from a latch write or from a new access. Second, a back-to-back run of video accesses counts as a single access for the wait request.

The stimulus drives every input a short time after the rising edge and holds it for the whole cycle. It runs both isolated accesses and runs where `mem_en` stays high over several video addresses, so the one-wait-per-access rule is exercised. Latch writes are issued both on idle cycles and during accesses.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int CTL_W = 8;

    // latch bit positions
    localparam int B_RAM_BOOT = 0;
    localparam int B_RAM_PROM = 1;
    localparam int B_RAM_CART = 2;
    localparam int B_EXT_LO   = 3;
    localparam int B_EXT_HI   = 4;
    localparam int B_VID_WAIT = 5;

    typedef enum logic [2:0] {
        DEV_NONE, DEV_ROM, DEV_PROM, DEV_CART, DEV_EXT, DEV_RAM, DEV_VID
    } dev_e;

    typedef struct packed {
        logic [CTL_W-1:0] bits;
    } ctl_s;

    typedef struct packed {
        logic vid_prev;
        logic wait_on;
    } wait_s;
endpackage

// File: rtl/ovl_ctl_latch.sv
module ovl_ctl_latch
    import ovl_pkg::*;
#(
    parameter int              BIO_AW   = 12,
    parameter logic [BIO_AW-1:0] BIO_BASE = 12'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BIO_AW-1:0] bio_addr,
    input  logic              bio_wdata,
    input  logic              bio_wstb,
    output logic [CTL_W-1:0]  ctl,
    output logic              bio_rdata
);
    localparam int OFS_W = $clog2(CTL_W);

    ctl_s             ctl_d, ctl_q;
    logic             hit;
    logic [OFS_W-1:0] ofs;
    logic [CTL_W-1:0] we;

    assign hit = (bio_addr[BIO_AW-1:OFS_W] == BIO_BASE[BIO_AW-1:OFS_W]);
    assign ofs = bio_addr[OFS_W-1:0];

    for (genvar i = 0; i < CTL_W; i++) begin : g_we
        assign we[i] = bio_wstb && hit && (ofs == OFS_W'(i));
    end

    always_comb begin
        ctl_d = ctl_q;
        for (int i = 0; i < CTL_W; i++) begin
            if (we[i]) ctl_d.bits[i] = bio_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl       = ctl_q.bits;
    assign bio_rdata = hit ? ctl_q.bits[ofs] : 1'b0;
endmodule

// File: rtl/ovl_region_decode.sv
module ovl_region_decode
    import ovl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              mem_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTL_W-1:0]  ctl,
    output dev_e              dev
);
    localparam int PAGE_W = 3;   // 8 KB pages
    localparam int VID_W  = 5;   // 2 KB granules

    logic [PAGE_W-1:0] page;
    logic              vid_hit;

    assign page    = addr[ADDR_W-1 -: PAGE_W];
    assign vid_hit = (addr[ADDR_W-1 -: VID_W] == 5'b10001);

    always_comb begin
        dev = DEV_NONE;
        if (mem_en) begin
            case (page)
                3'd0:    dev = ctl[B_RAM_BOOT] ? DEV_RAM : DEV_ROM;
                3'd1:    dev = ctl[B_EXT_LO]   ? DEV_EXT : DEV_RAM;
                3'd2:    dev = ctl[B_RAM_PROM] ? DEV_RAM : DEV_PROM;
                3'd3:    dev = ctl[B_RAM_CART] ? DEV_RAM : DEV_CART;
                3'd4:    dev = vid_hit         ? DEV_VID : DEV_NONE;
                default: dev = ctl[B_EXT_HI]   ? DEV_EXT : DEV_RAM;
            endcase
        end
    end
endmodule

// File: rtl/ovl_wait_gen.sv
module ovl_wait_gen
    import ovl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vid_acc,
    input  logic enable,
    output logic wait_req
);
    wait_s w_d, w_q;

    always_comb begin
        w_d          = w_q;
        w_d.vid_prev = vid_acc;
        w_d.wait_on  = vid_acc && !w_q.vid_prev && enable;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign wait_req = w_q.wait_on;
endmodule

// File: rtl/ovl_overlay_decoder.sv
module ovl_overlay_decoder
    import ovl_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              BIO_AW   = 12,
    parameter logic [BIO_AW-1:0] BIO_BASE = 12'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BIO_AW-1:0] bio_addr,
    input  logic              bio_wdata,
    input  logic              bio_wstb,
    output logic              bio_rdata,
    output logic              cs_rom,
    output logic              cs_prom,
    output logic              cs_cart,
    output logic              cs_ext,
    output logic              cs_ram,
    output logic              cs_vid,
    output logic              wait_req
);
    logic [CTL_W-1:0] ctl_q;
    dev_e             dev;

    ovl_ctl_latch #(.BIO_AW(BIO_AW), .BIO_BASE(BIO_BASE)) u_latch (
        .clk(clk), .rst_n(rst_n), .bio_addr(bio_addr), .bio_wdata(bio_wdata),
        .bio_wstb(bio_wstb), .ctl(ctl_q), .bio_rdata(bio_rdata)
    );

    ovl_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .mem_en(mem_en), .addr(addr), .ctl(ctl_q), .dev(dev)
    );

    ovl_wait_gen u_wait (
        .clk(clk), .rst_n(rst_n), .vid_acc(dev == DEV_VID),
        .enable(ctl_q[B_VID_WAIT]), .wait_req(wait_req)
    );

    assign cs_rom  = (dev == DEV_ROM);
    assign cs_prom = (dev == DEV_PROM);
    assign cs_cart = (dev == DEV_CART);
    assign cs_ext  = (dev == DEV_EXT);
    assign cs_ram  = (dev == DEV_RAM);
    assign cs_vid  = (dev == DEV_VID);
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_en,
    input logic [15:0] addr,
    input logic [7:0]  ctl,
    input logic        cs_rom,
    input logic        cs_prom,
    input logic        cs_cart,
    input logic        cs_ext,
    input logic        cs_ram,
    input logic        cs_vid,
    input logic        wait_req
);
    logic [5:0] sel;
    assign sel = {cs_rom, cs_prom, cs_cart, cs_ext, cs_ram, cs_vid};

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> (sel == 6'b0));
    p_vid_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && addr[15:11] == 5'b10001) |-> cs_vid);
    p_no_wt_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && addr[15:13] == 3'd0 && !ctl[0]) |-> !cs_ram);
    p_no_wt_cart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && addr[15:13] == 3'd3 && !ctl[2]) |-> !cs_ram);
    p_wait_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |=> !wait_req);
    p_wait_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> $past(cs_vid));
endmodule

bind ovl_overlay_decoder ovl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .addr(addr), .ctl(ctl_q),
    .cs_rom(cs_rom), .cs_prom(cs_prom), .cs_cart(cs_cart), .cs_ext(cs_ext),
    .cs_ram(cs_ram), .cs_vid(cs_vid), .wait_req(wait_req)
);

// File: tb/tb_ovl_overlay_decoder.sv
`timescale 1ns/1ps
module tb_ovl_overlay_decoder;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        mem_en = 0;
    logic [15:0] addr = 0;
    logic [11:0] bio_addr = 0;
    logic        bio_wdata = 0;
    logic        bio_wstb = 0;
    logic        bio_rdata, cs_rom, cs_prom, cs_cart, cs_ext, cs_ram, cs_vid, wait_req;

    int    checks = 0, failures = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model state
    bit [7:0] m_latch;
    bit       m_prev, m_wait;

    always #5 clk = ~clk;

    ovl_overlay_decoder dut (.*);

    // expected selects {rom,prom,cart,ext,ram,vid}
    function automatic bit [5:0] exp_sel(int a, bit [7:0] l, bit en);
        if (!en) return 6'b0;
        if (a < 'h2000) return l[0] ? 6'b000010 : 6'b100000;
        if (a < 'h4000) return l[3] ? 6'b000100 : 6'b000010;
        if (a < 'h6000) return l[1] ? 6'b000010 : 6'b010000;
        if (a < 'h8000) return l[2] ? 6'b000010 : 6'b001000;
        if (a < 'hA000) return (a >= 'h8800 && a < 'h9000) ? 6'b000001 : 6'b0;
        return l[4] ? 6'b000100 : 6'b000010;
    endfunction

    function automatic bit exp_rd(int ba, bit [7:0] l);
        if (ba >= 'h400 && ba < 'h408) return l[ba - 'h400];
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        bit vnow;
        if (!rst_n) begin
            m_latch = 0; m_prev = 0; m_wait = 0;
        end else begin
            vnow   = exp_sel(addr, m_latch, mem_en)[0];
            m_wait = vnow && !m_prev && m_latch[5];
            m_prev = vnow;
            if (bio_wstb && bio_addr >= 'h400 && bio_addr < 'h408)
                m_latch[bio_addr - 'h400] = bio_wdata;
        end
    end

    always @(negedge clk) begin
        bit [5:0] got, exp;
        if (rst_n && !done) begin
            got = {cs_rom, cs_prom, cs_cart, cs_ext, cs_ram, cs_vid};
            exp = exp_sel(addr, m_latch, mem_en);
            checks++;
            if (got !== exp) begin
                failures++;
                $display("FAIL %s sel addr=%h got=%b exp=%b", cur_req, addr, got, exp);
            end
            checks++;
            if (wait_req !== m_wait) begin
                failures++;
                $display("FAIL %s wait_req got=%b exp=%b", cur_req, wait_req, m_wait);
            end
            checks++;
            if (bio_rdata !== exp_rd(bio_addr, m_latch)) begin
                failures++;
                $display("FAIL %s bio_rdata ba=%h got=%b exp=%b", cur_req, bio_addr,
                         bio_rdata, exp_rd(bio_addr, m_latch));
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic set_bit(int k, bit v);
        bio_addr = 12'(12'h400 + k); bio_wdata = v; bio_wstb = 1;
        step();
        bio_wstb = 0;
    endtask

    task automatic access(int a);
        mem_en = 1; addr = 16'(a);
        step();
        mem_en = 0;
        step();
    endtask

    task automatic sweep();
        for (int i = 0; i < 32; i++) begin
            access(i * 'h800 + ((i % 2) ? 'h7FE : 0));
        end
    endtask

    task automatic read_all_bits();
        for (int k = 0; k < 10; k++) begin
            bio_addr = 12'(12'h3FF + k);
            step();
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired in phase %s", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: reset state readback and default map
        cur_req = "R1";
        read_all_bits();
        cur_req = "R2";
        sweep();
        // R9: ROM-type areas not overlaid never select RAM
        cur_req = "R9";
        access('h0100); access('h4abc); access('h7000);
        // R3 / R4 / R5 / R6 / R7 each bit alone
        cur_req = "R3"; set_bit(0, 1); sweep(); set_bit(0, 0);
        cur_req = "R4"; set_bit(1, 1); sweep(); set_bit(1, 0);
        cur_req = "R5"; set_bit(2, 1); sweep(); set_bit(2, 0);
        cur_req = "R6"; set_bit(3, 1); sweep(); set_bit(3, 0);
        cur_req = "R7"; set_bit(4, 1); sweep();
        // R8: all bits set, video region unchanged
        cur_req = "R8";
        for (int k = 0; k < 8; k++) set_bit(k, 1);
        sweep();
        read_all_bits();
        for (int k = 0; k < 8; k++) set_bit(k, 0);
        // R11: out-of-range strobes ignored
        cur_req = "R11";
        bio_addr = 12'h3FF; bio_wdata = 1; bio_wstb = 1; step();
        bio_addr = 12'h408; step();
        bio_addr = 12'hC00; step();
        bio_wstb = 0;
        read_all_bits();
        sweep();
        // R12: spare bits hold values
        cur_req = "R12";
        set_bit(6, 1); set_bit(7, 1); read_all_bits();
        set_bit(6, 0); read_all_bits(); set_bit(7, 0);
        // shadow copy sequence, latch write during an access
        cur_req = "R4";
        set_bit(1, 1); access('h0000); access('h4000);
        cur_req = "R3";
        mem_en = 1; addr = 16'h0010;
        set_bit(0, 1);
        step(); mem_en = 0; step();
        access('h4000); access('h0000);
        set_bit(1, 0); sweep();
        set_bit(0, 0);
        // R10: video wait
        cur_req = "R10";
        access('h8800);          // wait disabled
        set_bit(5, 1);
        access('h8800); access('h8FFE); access('h8000);
        mem_en = 1; addr = 16'h8C00; step(); step(); step();
        addr = 16'h8D00; step();
        addr = 16'h9000; step();
        addr = 16'h8802; step();
        mem_en = 0; step(); step();
        mem_en = 1; addr = 16'h8800; step();
        mem_en = 0; step();
        set_bit(5, 0);
        access('h8800);
        step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule